// File: doc/BRIEF.md
# Timed Event Scheduler CAM

The block keeps a small table of pending output events. Each event pairs a time value with a command. The command selects which of two free-running timers the time is compared against. It also says whether an output channel is driven high or low, whether an interrupt pulse is raised, and whether the entry stays in the table after it fires. Software loads a command register first and then writes a time value. The time write moves the pair into a holding register, and from there into the lowest free table slot on the next cycle.

A scan pointer visits one table slot per clock (one state time) in round-robin order. It compares that entry's time with the timer the entry selects. On a match the action is carried out and the entry is freed, unless it is locked and locking is globally enabled. Pin actions go into a staging copy. The visible pins load from that copy only on the last state of each eight-state frame. Software-timer, converter-start and secondary-timer-reset actions come out at once as one-cycle pulses. A flush input empties the whole table, locked entries included. A busy flag is high while the holding register has not yet found a free slot.

Top module: `evsched_cam`

## Requirements
- R1: After reset the pins, the pulse outputs and the busy flag are all low, and the table is empty.
- R2: A command write on its own does not enter the table and does not set the busy flag. Only a time write transfers the last command together with that time.
- R3: The command byte is laid out as bit 7 lock, bit 6 timer select (1 = secondary timer, 0 = main timer), bit 5 level (1 = set, 0 = clear), bit 4 interrupt enable, and bits 3:0 channel. An entry fires only when the timer it selects equals its time. Later entries do not remove earlier ones, so a pending event is countered only by a later opposite event.
- R4: An unlocked entry is freed when it fires, so its time recurring later has no effect.
- R5: An entry with the lock bit fires every time its time recurs while lock enable is high. If lock enable is low, the entry is freed after its first firing.
- R6: A flush pulse empties the table, locked entries included, and no flushed entry fires afterwards.
- R7: Channels 0 to 5 drive one pin each. Channel 6 drives pins 0 and 1 together, and channel 7 drives pins 2 and 3 together. Channels 8 to 11 pulse software-timer bit 0 to 3. Channel 14 pulses the secondary-timer reset, channel 15 pulses converter start, and channels 12 and 13 do nothing.
- R8: The interrupt output pulses once per firing, and only for entries with the interrupt enable bit set.
- R9: The pins change only on the clock edge that ends each eight-state frame, counted from reset release.
- R10: With every slot occupied, a time write waits in the holding register with the busy flag high. It enters the table as soon as a slot frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_data | input | 8 | Command byte |
| time_wr | input | 1 | Time write strobe, moves the pair to the holding register |
| time_data | input | 16 | Event time |
| lock_en | input | 1 | Global enable for entry locking |
| flush | input | 1 | Empties the table |
| main_time | input | 16 | Main timer value |
| aux_time | input | 16 | Secondary timer value |
| pins | output | 6 | Output channel pins |
| swt_hit | output | 4 | Software-timer pulses |
| irq | output | 1 | Interrupt pulse |
| adc_go | output | 1 | Converter start pulse |
| aux_clr | output | 1 | Secondary-timer reset pulse |
| hold_busy | output | 1 | Holding register occupied |

## Verification
The hardest situation to reach is a locked entry firing a second time. The scan revisits each slot every eight cycles, so a timer that stays on the matching value fires a locked entry again and again. The stimulus therefore holds the matching timer value for exactly eight cycles, which gives exactly one visit, then moves it away and back before counting interrupts. Filling the table to push a ninth write into waiting takes eight back-to-back inserts at times that never match, followed by one deliberate match that frees a slot.

// File: rtl/evsched_pkg.sv
package evsched_pkg;

   localparam int CHAN_W  = 4;
   localparam int PIN_CNT = 6;
   localparam int SWT_CNT = 4;

   localparam logic [CHAN_W-1:0] CH_PAIR_A  = 4'd6;
   localparam logic [CHAN_W-1:0] CH_PAIR_B  = 4'd7;
   localparam logic [CHAN_W-1:0] CH_AUX_CLR = 4'd14;
   localparam logic [CHAN_W-1:0] CH_ADC     = 4'd15;

   typedef struct packed {
      logic              lock;
      logic              aux_sel;
      logic              set_pin;
      logic              irq_en;
      logic [CHAN_W-1:0] chan;
   } ev_cmd_t;

   function automatic logic [PIN_CNT-1:0] pin_mask(input logic [CHAN_W-1:0] ch);
      logic [PIN_CNT-1:0] m;
      m = '0;
      if (ch < CHAN_W'(PIN_CNT))  m[ch[2:0]] = 1'b1;
      else if (ch == CH_PAIR_A)   m = 6'b000011;
      else if (ch == CH_PAIR_B)   m = 6'b001100;
      return m;
   endfunction

   function automatic logic [SWT_CNT-1:0] swt_mask(input logic [CHAN_W-1:0] ch);
      logic [SWT_CNT-1:0] m;
      m = '0;
      if (ch[3:2] == 2'b10) m[ch[1:0]] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/evsched_hold.sv
module evsched_hold
   import evsched_pkg::*;
#(
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  ev_cmd_t           cmd_in,
   input  logic              time_wr,
   input  logic [TIME_W-1:0] time_in,
   input  logic              take,
   output logic              full,
   output ev_cmd_t           hold_cmd,
   output logic [TIME_W-1:0] hold_time
);

   ev_cmd_t cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q     <= '0;
         hold_cmd  <= '0;
         hold_time <= '0;
         full      <= 1'b0;
      end else begin
         if (cmd_wr) cmd_q <= cmd_in;
         if (time_wr) begin
            hold_cmd  <= cmd_q;
            hold_time <= time_in;
            full      <= 1'b1;
         end else if (take) begin
            full <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/evsched_table.sv
module evsched_table
   import evsched_pkg::*;
#(
   parameter int N_ENT  = 8,
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_req,
   input  ev_cmd_t           ins_cmd,
   input  logic [TIME_W-1:0] ins_time,
   input  logic              flush,
   input  logic              lock_en,
   input  logic [TIME_W-1:0] main_time,
   input  logic [TIME_W-1:0] aux_time,
   output logic              take,
   output logic              fire,
   output ev_cmd_t           fire_cmd,
   output logic [N_ENT-1:0]  valid
);

   localparam int  IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1;
   localparam bit  POW2   = ((1 << IDX_W) == N_ENT);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

   ev_cmd_t           cmd_mem  [N_ENT];
   logic [TIME_W-1:0] time_mem [N_ENT];
   logic [N_ENT-1:0]  valid_q, valid_d;
   logic [IDX_W-1:0]  ptr_q, ptr_nx, free_idx;
   logic              has_free, hit, keep;
   ev_cmd_t           cur_cmd;
   logic [TIME_W-1:0] ref_time;

   // lowest free slot
   always_comb begin
      has_free = 1'b0;
      free_idx = '0;
      for (int i = N_ENT - 1; i >= 0; i--) begin
         if (!valid_q[i]) begin
            has_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   assign take     = ins_req && has_free && !flush;
   assign cur_cmd  = cmd_mem[ptr_q];
   assign ref_time = cur_cmd.aux_sel ? aux_time : main_time;
   assign hit      = valid_q[ptr_q] && (ref_time == time_mem[ptr_q]);
   assign keep     = cur_cmd.lock && lock_en;

   generate
      if (POW2) begin : g_wrap_nat
         assign ptr_nx = ptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_nx = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_comb begin
      valid_d = valid_q;
      if (flush) begin
         valid_d = '0;
      end else begin
         if (hit && !keep) valid_d[ptr_q] = 1'b0;
         if (take)         valid_d[free_idx] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= '0;
         ptr_q    <= '0;
         fire     <= 1'b0;
         fire_cmd <= '0;
         for (int i = 0; i < N_ENT; i++) begin
            cmd_mem[i]  <= '0;
            time_mem[i] <= '0;
         end
      end else begin
         valid_q  <= valid_d;
         ptr_q    <= ptr_nx;
         fire     <= hit && !flush;
         fire_cmd <= cur_cmd;
         if (take) begin
            cmd_mem[free_idx]  <= ins_cmd;
            time_mem[free_idx] <= ins_time;
         end
      end
   end

   assign valid = valid_q;

endmodule

// File: rtl/evsched_action.sv
module evsched_action
   import evsched_pkg::*;
#(
   parameter int BOUND_LOG2 = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fire,
   input  ev_cmd_t               fire_cmd,
   output logic [PIN_CNT-1:0]    pins,
   output logic [SWT_CNT-1:0]    swt_hit,
   output logic                  irq,
   output logic                  adc_go,
   output logic                  aux_clr,
   output logic [BOUND_LOG2-1:0] phase
);

   logic [BOUND_LOG2-1:0] phase_q;
   logic [PIN_CNT-1:0]    shadow_q, mask;
   logic                  frame_end;

   assign mask      = pin_mask(fire_cmd.chan);
   assign frame_end = (phase_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= '0;
         shadow_q <= '0;
         swt_hit  <= '0;
         irq      <= 1'b0;
         adc_go   <= 1'b0;
         aux_clr  <= 1'b0;
      end else begin
         phase_q <= phase_q + 1'b1;
         if (fire) begin
            shadow_q <= fire_cmd.set_pin ? (shadow_q | mask) : (shadow_q & ~mask);
         end
         swt_hit <= fire ? swt_mask(fire_cmd.chan) : '0;
         irq     <= fire && fire_cmd.irq_en;
         adc_go  <= fire && (fire_cmd.chan == CH_ADC);
         aux_clr <= fire && (fire_cmd.chan == CH_AUX_CLR);
      end
   end

   generate
      for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
         logic pin_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         pin_q <= 1'b0;
            else if (frame_end) pin_q <= shadow_q[p];
         end
         assign pins[p] = pin_q;
      end
   endgenerate

   assign phase = phase_q;

endmodule

// File: rtl/evsched_cam.sv
module evsched_cam
   import evsched_pkg::*;
#(
   parameter int N_ENT      = 8,
   parameter int TIME_W     = 16,
   parameter int BOUND_LOG2 = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [7:0]        cmd_data,
   input  logic              time_wr,
   input  logic [TIME_W-1:0] time_data,
   input  logic              lock_en,
   input  logic              flush,
   input  logic [TIME_W-1:0] main_time,
   input  logic [TIME_W-1:0] aux_time,
   output logic [5:0]        pins,
   output logic [3:0]        swt_hit,
   output logic              irq,
   output logic              adc_go,
   output logic              aux_clr,
   output logic              hold_busy
);

   generate
      if (N_ENT < 2)       begin : g_bad_depth $error("N_ENT must be at least 2"); end
      if (TIME_W < 2)      begin : g_bad_width $error("TIME_W must be at least 2"); end
      if (BOUND_LOG2 < 1)  begin : g_bad_frame $error("BOUND_LOG2 must be at least 1"); end
      if ($bits(ev_cmd_t) != 8) begin : g_bad_cmd $error("command must be one byte"); end
   endgenerate

   ev_cmd_t               hold_cmd, fire_cmd;
   logic [TIME_W-1:0]     hold_time;
   logic                  take, fire;
   logic [N_ENT-1:0]      tbl_valid;
   logic [BOUND_LOG2-1:0] phase_w;

   evsched_hold #(.TIME_W(TIME_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr),
      .cmd_in    (ev_cmd_t'(cmd_data)),
      .time_wr   (time_wr),
      .time_in   (time_data),
      .take      (take),
      .full      (hold_busy),
      .hold_cmd  (hold_cmd),
      .hold_time (hold_time)
   );

   evsched_table #(.N_ENT(N_ENT), .TIME_W(TIME_W)) u_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_req   (hold_busy),
      .ins_cmd   (hold_cmd),
      .ins_time  (hold_time),
      .flush     (flush),
      .lock_en   (lock_en),
      .main_time (main_time),
      .aux_time  (aux_time),
      .take      (take),
      .fire      (fire),
      .fire_cmd  (fire_cmd),
      .valid     (tbl_valid)
   );

   evsched_action #(.BOUND_LOG2(BOUND_LOG2)) u_act (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .fire_cmd (fire_cmd),
      .pins     (pins),
      .swt_hit  (swt_hit),
      .irq      (irq),
      .adc_go   (adc_go),
      .aux_clr  (aux_clr),
      .phase    (phase_w)
   );

endmodule

// File: rtl/evsched_cam_chk.sv
module evsched_cam_chk #(
   parameter int N_ENT      = 8,
   parameter int BOUND_LOG2 = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cmd_wr,
   input logic                  time_wr,
   input logic                  flush,
   input logic                  hold_busy,
   input logic [5:0]            pins,
   input logic [3:0]            swt_hit,
   input logic                  adc_go,
   input logic                  aux_clr,
   input logic [N_ENT-1:0]      tbl_valid,
   input logic [BOUND_LOG2-1:0] phase_w
);

   assert_cmd_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !time_wr && !hold_busy) |=> !hold_busy);

   assert_time_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      time_wr |=> hold_busy);

   assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (tbl_valid == '0));

   assert_pin_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pins) |-> ($past(phase_w) == '1));

   assert_one_special_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({adc_go, aux_clr, swt_hit}));

endmodule

bind evsched_cam evsched_cam_chk #(.N_ENT(N_ENT), .BOUND_LOG2(BOUND_LOG2)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_wr    (cmd_wr),
   .time_wr   (time_wr),
   .flush     (flush),
   .hold_busy (hold_busy),
   .pins      (pins),
   .swt_hit   (swt_hit),
   .adc_go    (adc_go),
   .aux_clr   (aux_clr),
   .tbl_valid (tbl_valid),
   .phase_w   (phase_w)
);

// File: tb/evsched_cam_tb.sv
`timescale 1ns/1ps
module evsched_cam_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0, time_wr = 1'b0, lock_en = 1'b0, flush = 1'b0;
   logic [7:0]  cmd_data = '0;
   logic [15:0] time_data = '0, main_time = 16'd100, aux_time = 16'd200;
   logic [5:0]  pins;
   logic [3:0]  swt_hit;
   logic        irq, adc_go, aux_clr, hold_busy;

   int checks = 0, fails = 0;
   int irq_cnt = 0, adc_cnt = 0, aux_cnt = 0;
   int swt_cnt [4] = '{0, 0, 0, 0};
   int edge_cnt = 0, frame_viol = 0;
   logic [5:0] prev_pins = '0;
   bit done = 0;

   always #10 clk = ~clk;

   evsched_cam u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
      .time_wr(time_wr), .time_data(time_data), .lock_en(lock_en), .flush(flush),
      .main_time(main_time), .aux_time(aux_time), .pins(pins), .swt_hit(swt_hit),
      .irq(irq), .adc_go(adc_go), .aux_clr(aux_clr), .hold_busy(hold_busy)
   );

   always @(posedge clk) if (rst_n) edge_cnt++;

   always @(negedge clk) begin
      if (rst_n) begin
         if (irq)     irq_cnt++;
         if (adc_go)  adc_cnt++;
         if (aux_clr) aux_cnt++;
         for (int k = 0; k < 4; k++) if (swt_hit[k]) swt_cnt[k]++;
         if (pins != prev_pins && (edge_cnt % 8) != 0) frame_viol++;
         prev_pins = pins;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_cmd(input bit lk, input bit ax, input bit st, input bit ie, input int ch);
      cmd_data = {lk, ax, st, ie, 4'(ch)};
      cmd_wr = 1'b1;
      cyc(1);
      cmd_wr = 1'b0;
   endtask

   task automatic wr_time(input int t);
      time_data = 16'(t);
      time_wr = 1'b1;
      cyc(1);
      time_wr = 1'b0;
      cyc(2);
   endtask

   function automatic logic [5:0] exp_mask(input int ch);
      if (ch < 6)  return 6'(1 << ch);
      if (ch == 6) return 6'b000011;
      if (ch == 7) return 6'b001100;
      return 6'b0;
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      logic [5:0] exp_pins;
      int exp_irq, exp_adc, exp_aux, base;
      int exp_swt [4];
      exp_swt = '{0, 0, 0, 0};
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk(pins == 0, "R1 pins", pins, 0);
      chk(hold_busy == 0, "R1 busy", hold_busy, 0);
      chk({irq, adc_go, aux_clr, swt_hit} == 0, "R1 pulses", {irq, adc_go, aux_clr, swt_hit}, 0);

      // R2 command alone: holding time is 0, drive timer to 0 and to the written time
      wr_cmd(0, 0, 1, 1, 0);
      cyc(2);
      chk(hold_busy == 0, "R2 busy after cmd", hold_busy, 0);
      main_time = 16'd0;    cyc(20);
      main_time = 16'd100;  cyc(20);
      chk(pins == 0, "R2 pins", pins, 0);
      chk(irq_cnt == 0, "R2 irq", irq_cnt, 0);

      // R7/R3/R8 sweep of every channel: set with interrupt
      exp_pins = '0; exp_irq = 0; exp_adc = 0; exp_aux = 0;
      for (int ch = 0; ch < 16; ch++) begin
         wr_cmd(0, 0, 1, 1, ch);
         wr_time(1000 + ch);
         main_time = 16'(1000 + ch);
         cyc(24);
         main_time = 16'd100;
         exp_pins |= exp_mask(ch);
         exp_irq++;
         if (ch >= 8 && ch <= 11) exp_swt[ch-8]++;
         if (ch == 14) exp_aux++;
         if (ch == 15) exp_adc++;
         chk(pins == exp_pins, $sformatf("R7 set pins ch%0d", ch), pins, exp_pins);
         chk(irq_cnt == exp_irq, $sformatf("R8 irq ch%0d", ch), irq_cnt, exp_irq);
         chk(adc_cnt == exp_adc && aux_cnt == exp_aux, $sformatf("R7 adc/aux ch%0d", ch),
             adc_cnt * 10 + aux_cnt, exp_adc * 10 + exp_aux);
         for (int k = 0; k < 4; k++)
            chk(swt_cnt[k] == exp_swt[k], $sformatf("R7 swt%0d ch%0d", k, ch), swt_cnt[k], exp_swt[k]);
      end

      // clear sweep without interrupt enable
      for (int ch = 7; ch >= 0; ch--) begin
         wr_cmd(0, 0, 0, 0, ch);
         wr_time(1100 + ch);
         main_time = 16'(1100 + ch);
         cyc(24);
         main_time = 16'd100;
         exp_pins &= ~exp_mask(ch);
         chk(pins == exp_pins, $sformatf("R7 clear pins ch%0d", ch), pins, exp_pins);
         chk(irq_cnt == exp_irq, $sformatf("R8 no irq ch%0d", ch), irq_cnt, exp_irq);
      end

      // R3 timer select: secondary-timer entry ignores the main timer
      wr_cmd(0, 1, 1, 0, 2);
      wr_time(500);
      main_time = 16'd500; cyc(24); main_time = 16'd100;
      chk(pins[2] == 0, "R3 main timer ignored", pins[2], 0);
      aux_time = 16'd500; cyc(24); aux_time = 16'd200;
      chk(pins[2] == 1, "R3 aux timer match", pins[2], 1);

      // R3 no cancel: opposite event written before the first fires
      wr_cmd(0, 0, 1, 0, 3); wr_time(1500);
      wr_cmd(0, 0, 0, 0, 3); wr_time(1600);
      main_time = 16'd1500; cyc(24);
      chk(pins[3] == 1, "R3 first event kept", pins[3], 1);
      main_time = 16'd1600; cyc(24); main_time = 16'd100;
      chk(pins[3] == 0, "R3 opposite event", pins[3], 0);

      // R4 unlocked entry freed
      base = irq_cnt;
      wr_cmd(0, 0, 1, 1, 12); wr_time(700);
      main_time = 16'd700; cyc(20); main_time = 16'd100; cyc(10);
      main_time = 16'd700; cyc(20); main_time = 16'd100; cyc(4);
      chk(irq_cnt == base + 1, "R4 one shot", irq_cnt, base + 1);

      // R5 locked entry repeats while lock enable is high (timer held exactly 8 cycles)
      lock_en = 1'b1;
      base = irq_cnt;
      wr_cmd(1, 0, 1, 1, 12); wr_time(800);
      for (int r = 0; r < 3; r++) begin
         main_time = 16'd800; cyc(8); main_time = 16'd100; cyc(6);
      end
      chk(irq_cnt == base + 3, "R5 locked repeats", irq_cnt, base + 3);

      // R6 flush removes the locked entry
      flush = 1'b1; cyc(1); flush = 1'b0;
      base = irq_cnt;
      main_time = 16'd800; cyc(8); main_time = 16'd100; cyc(6);
      chk(irq_cnt == base, "R6 flushed locked", irq_cnt, base);

      // R5 lock bit without lock enable is one shot
      lock_en = 1'b0;
      wr_cmd(1, 0, 1, 1, 12); wr_time(900);
      for (int r = 0; r < 2; r++) begin
         main_time = 16'd900; cyc(8); main_time = 16'd100; cyc(6);
      end
      chk(irq_cnt == base + 1, "R5 lock disabled", irq_cnt, base + 1);

      // R10 full table: eight entries then a waiting ninth
      base = irq_cnt;
      wr_cmd(0, 0, 1, 1, 12);
      for (int e = 0; e < 8; e++) wr_time(2000 + e);
      chk(hold_busy == 0, "R10 eight accepted", hold_busy, 0);
      wr_time(3000);
      cyc(4);
      chk(hold_busy == 1, "R10 ninth waits", hold_busy, 1);
      main_time = 16'd3000; cyc(16);
      chk(irq_cnt == base, "R10 waiting not scanned", irq_cnt, base);
      main_time = 16'd2000; cyc(16);
      chk(hold_busy == 0, "R10 ninth entered", hold_busy, 0);
      main_time = 16'd3000; cyc(16); main_time = 16'd100; cyc(4);
      chk(irq_cnt == base + 2, "R10 ninth fired", irq_cnt, base + 2);

      // R6 flush a full-ish table of unlocked entries
      flush = 1'b1; cyc(1); flush = 1'b0;
      base = irq_cnt;
      for (int e = 1; e < 8; e++) begin
         main_time = 16'(2000 + e); cyc(10);
      end
      main_time = 16'd100; cyc(4);
      chk(irq_cnt == base, "R6 flushed entries", irq_cnt, base);

      // R9 frame-aligned pin updates over the whole run
      chk(frame_viol == 0, "R9 pin frame", frame_viol, 0);

      done = 1;
      summary();
      $finish;
   end

endmodule